// File: doc/BRIEF.md
# Age-Counter Victim Selector for a Four-Way Cache Set

This block keeps the recency state of one associative cache set and names the way to evict when the set misses. Each way owns a small age counter. A way that is touched gets age 0, and the ways that were more recent than it age by one. The four ages therefore always form an ordering from newest (0) to oldest (3). The oldest way is the victim.

The cache controller pulses an access strobe once per lookup. It also gives a hit flag and, on a hit, the way that matched. On a miss the line is filled into the way the block is showing as victim at that moment, and that way becomes the newest. A policy input can switch the victim choice to a pseudo-random way drawn from a free-running LFSR. In that mode the ages keep being updated, so switching back to age-based choice stays consistent at any time.

Tag storage, tag comparison, the data array and refill sequencing sit outside this block.

Top module: `lru_age_victim`

## Requirements
- R1: While reset is asserted, way i is loaded with age i (ways 0..3 get ages 0..3). With age-based policy selected, the first victim after reset is way 3 and the valid flag is high.
- R2: On a strobe with the hit flag high, the hit way has age 0 after the next rising clock edge.
- R3: On a hit, each other way whose age was below the old age of the hit way gains one. Each way whose age was above it keeps its age.
- R4: On a strobe with the hit flag low and age-based policy (policy input 0), the way shown as victim (age 3) takes age 0 and every other way gains one.
- R5: With age-based policy, the victim output is the index of the way whose age is 3. It follows the current ages combinationally, and the valid flag is high.
- R6: While the strobe is low, no age changes, whatever the hit flag, the way index and the policy input are.
- R7: The four ages are always a permutation of 0..3, so no counter saturates or wraps.
- R8: With random policy (policy input 1), the victim is the low 2 bits of an 8-bit LFSR and the valid flag is high. The LFSR resets to 0x01 and steps on every clock edge out of reset, whatever the other inputs. Each step shifts it left by one and puts the XOR of bits 7, 5, 4 and 3 into bit 0.
- R9: On a miss with random policy, the way shown as victim takes age 0. Ways that were younger than it gain one, and older ways keep their age.
- R10: On a miss, the way index input is ignored. Only the displayed victim is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access strobe, one lookup per cycle it is high |
| acc_hit | input | 1 | Lookup hit the set |
| acc_way | input | 2 | Way that hit; ignored on a miss |
| rand_mode | input | 1 | Victim policy: 0 age-based, 1 pseudo-random |
| victim_way | output | 2 | Way to replace on the next miss |
| victim_valid | output | 1 | Victim output is meaningful |

## Verification
The assertions assume that the way index on a hit is a real way of the set. They also assume that the policy input may change in any cycle without any notice. They assume nothing about how often the strobe is high or what follows a miss. The stimulus drives a long pseudo-random stream in which the strobe, hit flag, hit way and policy are all independent. Every input changes just after a clock edge and is held for a full cycle. This covers every hit way at every age, misses in both policies, idle cycles with noisy side inputs, and policy changes in the middle of a stream.

// File: rtl/lru_pkg.sv
package lru_pkg;

    typedef enum logic {
        POL_AGE  = 1'b0,
        POL_RAND = 1'b1
    } policy_e;

endpackage

// File: rtl/lru_lfsr_step.sv
module lru_lfsr_step #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     TAPS = 8'hB8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    logic fb;

    always_comb begin
        fb  = ^(cur & TAPS);
        nxt = {cur[W-2:0], fb};
    end
endmodule

// File: rtl/lru_age_cell.sv
module lru_age_cell #(
    parameter int IDX_W = 2,
    parameter int MY_IDX = 0
) (
    input  logic             upd,
    input  logic [IDX_W-1:0] touch_way,
    input  logic [IDX_W-1:0] touch_age,
    input  logic [IDX_W-1:0] age_cur,
    output logic [IDX_W-1:0] age_nxt
);
    localparam logic [IDX_W-1:0] ME = IDX_W'(MY_IDX);

    always_comb begin
        age_nxt = age_cur;
        if (upd) begin
            if (touch_way == ME) begin
                age_nxt = '0;
            end else if (age_cur < touch_age) begin
                age_nxt = age_cur + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lru_oldest_pick.sv
module lru_oldest_pick #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input  logic [WAYS-1:0][IDX_W-1:0] ages,
    output logic [IDX_W-1:0]           oldest_way,
    output logic                       oldest_unique
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(WAYS - 1);

    logic [WAYS-1:0]  is_old;
    logic [IDX_W:0]   n_old;

    always_comb begin
        oldest_way = '0;
        n_old      = '0;
        for (int i = 0; i < WAYS; i++) begin
            is_old[i] = (ages[i] == OLDEST);
            if (is_old[i]) begin
                oldest_way = IDX_W'(i);
                n_old      = n_old + 1'b1;
            end
        end
        oldest_unique = (n_old == (IDX_W+1)'(1));
    end
endmodule

// File: rtl/lru_age_victim.sv
module lru_age_victim #(
    parameter int                 WAYS      = 4,
    parameter int                 LFSR_W    = 8,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0]  LFSR_SEED = 8'h01
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic                      acc_hit,
    input  logic [$clog2(WAYS)-1:0]   acc_way,
    input  logic                      rand_mode,
    output logic [$clog2(WAYS)-1:0]   victim_way,
    output logic                      victim_valid
);
    import lru_pkg::*;

    localparam int IDX_W = $clog2(WAYS);

    typedef struct packed {
        logic [WAYS-1:0][IDX_W-1:0] age;
        logic [LFSR_W-1:0]          lfsr;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0]            oldest_way;
    logic                        oldest_unique;
    logic [IDX_W-1:0]            touch_way;
    logic [IDX_W-1:0]            touch_age;
    logic [WAYS-1:0][IDX_W-1:0]  age_nxt;
    logic [LFSR_W-1:0]           lfsr_nxt;
    policy_e                     policy;

    assign policy = policy_e'(rand_mode);

    lru_oldest_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) u_pick (
        .ages         (state_q.age),
        .oldest_way   (oldest_way),
        .oldest_unique(oldest_unique)
    );

    lru_lfsr_step #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
        .cur(state_q.lfsr),
        .nxt(lfsr_nxt)
    );

    always_comb begin
        if (policy == POL_RAND) begin
            victim_way   = state_q.lfsr[IDX_W-1:0];
            victim_valid = 1'b1;
        end else begin
            victim_way   = oldest_way;
            victim_valid = oldest_unique;
        end
        touch_way = acc_hit ? acc_way : victim_way;
        touch_age = state_q.age[touch_way];
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_cell
        lru_age_cell #(.IDX_W(IDX_W), .MY_IDX(g)) u_cell (
            .upd      (acc_valid),
            .touch_way(touch_way),
            .touch_age(touch_age),
            .age_cur  (state_q.age[g]),
            .age_nxt  (age_nxt[g])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.age  = age_nxt;
        state_d.lfsr = lfsr_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) begin
                state_q.age[i] <= IDX_W'(i);
            end
            state_q.lfsr <= LFSR_SEED;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/lru_age_victim_chk.sv
module lru_age_victim_chk #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic                    acc_hit,
    input logic [IDX_W-1:0]        acc_way,
    input logic                    rand_mode,
    input logic [IDX_W-1:0]        victim_way,
    input logic                    victim_valid,
    input logic [WAYS*IDX_W-1:0]   ages
);
    logic [WAYS-1:0][IDX_W-1:0] av;
    logic [WAYS-1:0][WAYS-1:0]  has_age;

    always_comb begin
        av = ages;
        for (int k = 0; k < WAYS; k++) begin
            for (int i = 0; i < WAYS; i++) begin
                has_age[k][i] = (av[i] == IDX_W'(k));
            end
        end
    end

    assert_reset_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (av[0] == 0 && av[1] == 1 && av[2] == 2 && av[3] == 3));

    assert_hit_newest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |=> av[$past(acc_way)] == '0);

    assert_miss_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |=> av[$past(victim_way)] == '0);  // also R9, R10

    assert_oldest_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rand_mode |-> (victim_valid && av[victim_way] == IDX_W'(WAYS-1)));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(ages));

    assert_rand_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rand_mode |-> victim_valid);

    for (genvar k = 0; k < WAYS; k++) begin : g_perm
        assert_age_perm_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(has_age[k]) == 1);
    end
endmodule

bind lru_age_victim lru_age_victim_chk #(.WAYS(WAYS), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_hit     (acc_hit),
    .acc_way     (acc_way),
    .rand_mode   (rand_mode),
    .victim_way  (victim_way),
    .victim_valid(victim_valid),
    .ages        (state_q.age)
);

// File: tb/lru_age_victim_tb.sv
module lru_age_victim_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_way = 2'd0;
    logic       rand_mode = 1'b0;
    logic [1:0] victim_way;
    logic       victim_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    lru_age_victim u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .rand_mode(rand_mode),
        .victim_way(victim_way), .victim_valid(victim_valid)
    );

    // reference state built from the requirements
    logic [1:0] m_age [4];
    logic [7:0] m_lfsr;

    function automatic logic [1:0] exp_victim();
        logic [1:0] v = 2'd0;
        if (rand_mode) return m_lfsr[1:0];
        for (int i = 0; i < 4; i++) if (m_age[i] == 2'd3) v = 2'(i);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_age[i] = 2'(i);
            m_lfsr = 8'h01;
        end else begin
            logic [1:0] t, ta;
            if (acc_valid) begin
                t  = acc_hit ? acc_way : exp_victim();
                ta = m_age[t];
                for (int i = 0; i < 4; i++) begin
                    if (2'(i) == t) m_age[i] = 2'd0;
                    else if (m_age[i] < ta) m_age[i] = m_age[i] + 2'd1;
                end
            end
            m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
        end
    end

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp, logic vact);
        n_chk++;
        if (act !== exp || vact !== 1'b1) begin
            n_bad++;
            $display("FAIL %s: victim=%0d valid=%0b expected victim=%0d valid=1",
                     tag, act, vact, exp);
        end
    endtask

    task automatic step(logic v, logic h, logic [1:0] w, logic m, string tag);
        acc_valid = v; acc_hit = h; acc_way = w; rand_mode = m;
        @(posedge clk); #2;
        check(tag, victim_way, exp_victim(), victim_valid);
    endtask

    initial begin
        int unsigned seed = 32'h2468ace1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1 check("R1", victim_way, 2'd3, victim_valid);
        // idle with noisy side inputs: R6
        step(1'b0, 1'b1, 2'd3, 1'b0, "R6");
        step(1'b0, 1'b0, 2'd1, 1'b0, "R6");
        check("R6", victim_way, 2'd3, victim_valid);
        // hit oldest way: R2, next oldest is way 2 (R3)
        step(1'b1, 1'b1, 2'd3, 1'b0, "R2");
        check("R3", victim_way, 2'd2, victim_valid);
        // hit newest way 3 again: nothing else ages (R3)
        step(1'b1, 1'b1, 2'd3, 1'b0, "R3");
        check("R3", victim_way, 2'd2, victim_valid);
        // miss: way 2 filled, way 1 becomes oldest (R4), acc_way ignored (R10)
        step(1'b1, 1'b0, 2'd1, 1'b0, "R10");
        check("R4", victim_way, 2'd1, victim_valid);
        // random policy sweep of the LFSR: R8
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 2'd0, 1'b1, "R8");
        // long mixed stream: R4 R5 R7 R9
        for (int k = 0; k < 6000; k++) begin
            logic v, h, m;
            logic [1:0] w;
            string tg;
            seed = seed * 32'd1103515245 + 32'd12345;
            v = seed[20] | seed[21];
            h = seed[22] | seed[23];
            w = seed[25:24];
            m = (k % 800) > 500 ? seed[26] : 1'b0;
            if (!v) tg = "R6";
            else if (h) tg = "R3";
            else if (m) tg = "R9";
            else tg = "R4";
            if (!m && !v) tg = "R5";
            step(v, h, w, m, (k % 7 == 0) ? "R7" : tg);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not finish, expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule